// File: doc/BRIEF.md
# Dual-Clock FIFO with Loadable Threshold Flags

This block is a first-in first-out buffer whose write side and read side run on unrelated clocks. Words enter on the write clock and leave, in the same order, on the read clock. Four active-low status outputs report the fill level:

- empty and almost-empty are produced in the read domain.
- full and almost-full are produced in the write domain.

Each side sees the other side's position through a Gray-coded pointer. The pointer carries one extra wrap bit and passes through a two-flop synchronizer.

The level on the dual-role input `wen2_ld` while reset is low fixes its role until the next reset:

- **Held high during reset:** the pin is a second write enable. A write then needs `wen1_n` low and `wen2_ld` high.
- **Held low during reset:** the buffer runs in threshold-programming mode. `wen1_n` alone writes data while `wen2_ld` is high. Pulling `wen2_ld` low turns write cycles into loads of the two threshold registers, and turns read cycles into read-back of those registers.

The read data is registered. An output-enable input gates a data-valid indication; the data pins are never tri-stated.

Top module: `dual_clk_flag_fifo`

## Requirements
- R1: While `rst_n` is low, both pointers go to the first location. After reset, `empty_n`=0, `aempty_n`=0, `full_n`=1, `afull_n`=1 and `dout_vld`=0.
- R2: In two-enable mode (`wen2_ld`=1 during reset), a word is written on a rising `wclk` edge only when `wen1_n`=0 and `wen2_ld`=1. With `wen2_ld`=0, nothing is written.
- R3: In programming mode (`wen2_ld`=0 during reset):
  - With `wen2_ld`=1, `wen1_n`=0 alone writes a data word.
  - With `wen2_ld`=0, each `wclk` edge with `wen1_n`=0 stores data into the next threshold field and writes no data word.
  - Let H = ceil(log2(DEPTH)/2). The fields are taken in this order, then the order wraps: almost-empty bits [H-1:0], almost-empty upper bits, almost-full bits [H-1:0], almost-full upper bits.
  - Each field is taken from the low bits of `din`.
- R4: A word is read on a rising `rclk` edge only when `ren1_n`=0 and `ren2_n`=0. It appears on `dout` after that same edge. Words leave in write order.
- R5: A write while `full_n`=0 and a read while `empty_n`=0 have no effect. The stored word count never exceeds DEPTH.
- R6: `aempty_n` is 0 while the read side sees at most AE words stored, where AE is the almost-empty threshold (reset value 7).
- R7: `afull_n` is 0 while the write side sees at least DEPTH-AF words stored, where AF is the almost-full threshold (reset value 7).
- R8: In programming mode, with `wen2_ld`=0 and both read enables low, each `rclk` edge places the next threshold field on `dout`, zero-extended, in the same order as R3. No data word is consumed.
- R9: `dout_vld` is 1 exactly when `oe_n`=0 and at least one read or read-back has happened since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low reset, held for several cycles of both clocks |
| din | input | DW | Write data, or threshold field when loading |
| wen1_n | input | 1 | Primary write enable, active low |
| wen2_ld | input | 1 | Second write enable or load strobe, role fixed at reset |
| ren1_n | input | 1 | Read enable 1, active low |
| ren2_n | input | 1 | Read enable 2, active low |
| oe_n | input | 1 | Output enable, active low; gates `dout_vld` |
| dout | output | DW | Registered read data or threshold field |
| dout_vld | output | 1 | Output word valid |
| empty_n | output | 1 | Empty flag, active low, read domain |
| aempty_n | output | 1 | Almost-empty flag, active low, read domain |
| afull_n | output | 1 | Almost-full flag, active low, write domain |
| full_n | output | 1 | Full flag, active low, write domain |

## Verification
A write and a read can land in the same short interval on their two clocks. The buffer then has to accept the incoming word and hand out the oldest one without losing or repeating either. This is hardest at the edges, where a flag is about to change and the other side still sees a stale synchronized pointer.

The bench provokes this with a fast write clock and a slower, unrelated read clock. Both ports are driven with independently chosen enables, which pushes the buffer into full and back toward empty many times. Each side predicts acceptance from the flag it sees before its own clock edge. Every word read is judged against a reference queue filled only by predicted-accepted writes.

// File: rtl/dual_clk_flag_fifo.sv
module dual_clk_flag_fifo #(
  parameter int DW     = 9,
  parameter int DEPTH  = 2048,
  parameter int AE_DEF = 7,
  parameter int AF_DEF = 7
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          wen1_n,
  input  logic          wen2_ld,
  input  logic          ren1_n,
  input  logic          ren2_n,
  input  logic          oe_n,
  output logic [DW-1:0] dout,
  output logic          dout_vld,
  output logic          empty_n,
  output logic          aempty_n,
  output logic          afull_n,
  output logic          full_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int LO = (AW + 1) / 2;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  // write domain
  logic          pf_w;
  logic [PW-1:0] wbin, wgray, rg1, rg2, wcnt, wnx;
  logic [AW-1:0] ae_off, af_off;
  logic [1:0]    lsel;
  logic          wr_go, ld_go;

  // read domain
  logic          pf_r, got;
  logic [PW-1:0] rbin, rgray, wg1, wg2, rcnt, rnx;
  logic [1:0]    rsel;
  logic          rd_both, rb_go, rd_go;

  assign wnx     = wbin + PW'(1);
  assign wcnt    = wbin - g2b(rg2);
  assign full_n  = (wcnt != PW'(DEPTH));
  assign afull_n = (wcnt < (PW'(DEPTH) - PW'(af_off)));
  assign wr_go   = !wen1_n && wen2_ld && full_n;
  assign ld_go   = pf_w && !wen2_ld && !wen1_n;

  always_ff @(posedge wclk) begin
    if (!rst_n) begin
      pf_w   <= !wen2_ld;
      wbin   <= '0;
      wgray  <= '0;
      rg1    <= '0;
      rg2    <= '0;
      ae_off <= AW'(AE_DEF);
      af_off <= AW'(AF_DEF);
      lsel   <= '0;
    end else begin
      rg1 <= rgray;
      rg2 <= rg1;
      if (wr_go) begin
        wbin  <= wnx;
        wgray <= wnx ^ (wnx >> 1);
      end
      if (ld_go) begin
        case (lsel)
          2'd0: ae_off[LO-1:0]  <= din[LO-1:0];
          2'd1: ae_off[AW-1:LO] <= din[AW-LO-1:0];
          2'd2: af_off[LO-1:0]  <= din[LO-1:0];
          default: af_off[AW-1:LO] <= din[AW-LO-1:0];
        endcase
        lsel <= lsel + 2'd1;
      end
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_go) mem[wbin[AW-1:0]] <= din;
  end

  assign rnx      = rbin + PW'(1);
  assign rcnt     = g2b(wg2) - rbin;
  assign empty_n  = (rcnt != '0);
  assign aempty_n = (rcnt > PW'(ae_off));
  assign rd_both  = !ren1_n && !ren2_n;
  assign rb_go    = pf_r && !wen2_ld && rd_both;
  assign rd_go    = rd_both && empty_n && !rb_go;
  assign dout_vld = got && !oe_n;

  always_ff @(posedge rclk) begin
    if (!rst_n) begin
      pf_r  <= !wen2_ld;
      rbin  <= '0;
      rgray <= '0;
      wg1   <= '0;
      wg2   <= '0;
      rsel  <= '0;
      got   <= 1'b0;
      dout  <= '0;
    end else begin
      wg1 <= wgray;
      wg2 <= wg1;
      if (rd_go) begin
        dout  <= mem[rbin[AW-1:0]];
        rbin  <= rnx;
        rgray <= rnx ^ (rnx >> 1);
        got   <= 1'b1;
      end else if (rb_go) begin
        case (rsel)
          2'd0: dout <= DW'(ae_off[LO-1:0]);
          2'd1: dout <= DW'(ae_off[AW-1:LO]);
          2'd2: dout <= DW'(af_off[LO-1:0]);
          default: dout <= DW'(af_off[AW-1:LO]);
        endcase
        rsel <= rsel + 2'd1;
        got  <= 1'b1;
      end
    end
  end

  assert_no_write_when_full_R5: assert property (@(posedge wclk) disable iff (!rst_n)
    (!full_n) |=> $stable(wbin));
  assert_no_read_when_empty_R5: assert property (@(posedge rclk) disable iff (!rst_n)
    (!empty_n) |=> $stable(rbin));
  assert_count_bound_R5: assert property (@(posedge wclk) disable iff (!rst_n)
    wcnt <= PW'(DEPTH));
  assert_full_within_afull_R7: assert property (@(posedge wclk) disable iff (!rst_n)
    (!full_n) |-> (!afull_n));
  assert_empty_within_aempty_R6: assert property (@(posedge rclk) disable iff (!rst_n)
    (!empty_n) |-> (!aempty_n));
  assert_load_not_data_R3: assert property (@(posedge wclk) disable iff (!rst_n)
    ld_go |=> $stable(wbin));
endmodule

// File: tb/test_dual_clk_flag_fifo.sv
`timescale 1ns/1ps
module test_dual_clk_flag_fifo;
  localparam int DW = 9;
  localparam int DEPTH = 64;

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic [DW-1:0] din = '0;
  logic wen1_n = 1, wen2_ld = 1, ren1_n = 1, ren2_n = 1, oe_n = 0;
  logic [DW-1:0] dout;
  logic dout_vld, empty_n, aempty_n, afull_n, full_n;

  int checks = 0, errors = 0;
  logic [DW-1:0] q[$];
  bit finished = 0;

  always #2 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  dual_clk_flag_fifo #(.DW(DW), .DEPTH(DEPTH)) i_dual_clk_flag_fifo (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .din(din), .wen1_n(wen1_n),
    .wen2_ld(wen2_ld), .ren1_n(ren1_n), .ren2_n(ren2_n), .oe_n(oe_n),
    .dout(dout), .dout_vld(dout_vld), .empty_n(empty_n), .aempty_n(aempty_n),
    .afull_n(afull_n), .full_n(full_n));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    rst_n = 0; wen2_ld = strap; wen1_n = 1; ren1_n = 1; ren2_n = 1; oe_n = 0;
    q.delete();
    repeat (4) @(posedge rclk);
    @(negedge wclk); rst_n = 1; wen2_ld = 1;
    repeat (2) @(negedge wclk);
  endtask

  task automatic settle();
    repeat (5) @(posedge rclk);
    repeat (5) @(posedge wclk);
    @(negedge rclk);
  endtask

  task automatic wr(input logic [DW-1:0] d);
    @(negedge wclk); din = d; wen1_n = 0;
    if (full_n && wen2_ld) q.push_back(d);
    @(negedge wclk); wen1_n = 1;
  endtask

  task automatic rd(output logic [DW-1:0] d);
    @(negedge rclk); ren1_n = 0; ren2_n = 0;
    @(negedge rclk); ren1_n = 1; ren2_n = 1; d = dout;
  endtask

  task automatic drain_check(input string tag);
    logic [DW-1:0] d;
    while (q.size() > 0) begin
      rd(d);
      chk(tag, d, q.pop_front());
    end
  endtask

  task automatic t_reset();
    do_reset(1);
    chk("R1 empty_n", empty_n, 0);
    chk("R1 aempty_n", aempty_n, 0);
    chk("R1 full_n", full_n, 1);
    chk("R1 afull_n", afull_n, 1);
    chk("R9 dout_vld after reset", dout_vld, 0);
  endtask

  task automatic t_two_enable();
    logic [DW-1:0] d;
    do_reset(1);
    @(negedge wclk); wen2_ld = 0; din = 9'h0AA; wen1_n = 0;
    @(negedge wclk); wen1_n = 1; wen2_ld = 1;
    settle();
    chk("R2 blocked by second enable", empty_n, 0);
    wr(9'h155);
    settle();
    chk("R2 write with both enables", empty_n, 1);
    @(negedge rclk); ren1_n = 0; ren2_n = 1;
    @(negedge rclk); ren1_n = 1;
    settle();
    chk("R4 single read enable no read", empty_n, 1);
    rd(d);
    chk("R4 read data", d, q.pop_front());
    chk("R9 dout_vld after read", dout_vld, 1);
    oe_n = 1; #1;
    chk("R9 dout_vld gated by oe_n", dout_vld, 0);
    oe_n = 0;
    settle();
    rd(d);
    chk("R5 read on empty keeps dout", d, 9'h155);
    chk("R5 still empty", empty_n, 0);
    wr(9'h033);
    settle();
    drain_check("R5 data after empty read");
  endtask

  task automatic t_default_thresholds();
    do_reset(1);
    for (int i = 0; i < 7; i++) wr(DW'(10 + i));
    settle();
    chk("R6 aempty_n at 7 words", aempty_n, 0);
    wr(DW'(17));
    settle();
    chk("R6 aempty_n at 8 words", aempty_n, 1);
    for (int i = 8; i < DEPTH - 8; i++) wr(DW'(10 + i));
    settle();
    chk("R7 afull_n at DEPTH-8", afull_n, 1);
    wr(DW'(10 + DEPTH - 8));
    settle();
    chk("R7 afull_n at DEPTH-7", afull_n, 0);
    for (int i = DEPTH - 7; i < DEPTH; i++) wr(DW'(10 + i));
    settle();
    chk("R5 full_n at DEPTH", full_n, 0);
    wr(9'h1FF);
    settle();
    chk("R5 queue model size", q.size(), DEPTH);
    drain_check("R4 order after fill");
    settle();
    chk("R5 extra write dropped", empty_n, 0);
  endtask

  task automatic t_load();
    logic [DW-1:0] d;
    logic [DW-1:0] parts [4] = '{9'd2, 9'd1, 9'd4, 9'd0};
    do_reset(0);
    wen2_ld = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge wclk); din = parts[i]; wen1_n = 0;
    end
    @(negedge wclk); wen1_n = 1;
    settle();
    chk("R3 load writes no data", empty_n, 0);
    for (int i = 0; i < 4; i++) begin
      rd(d);
      chk("R8 read-back field", d, parts[i]);
    end
    rd(d);
    chk("R8 read-back wraps", d, parts[0]);
    chk("R9 dout_vld after read-back", dout_vld, 1);
    settle();
    chk("R8 read-back consumed nothing", empty_n, 0);
    wen2_ld = 1;
    for (int i = 0; i < 10; i++) wr(DW'(100 + i));
    settle();
    chk("R3 single enable writes", empty_n, 1);
    chk("R6 loaded threshold 10 words", aempty_n, 0);
    wr(DW'(110));
    settle();
    chk("R6 loaded threshold 11 words", aempty_n, 1);
    for (int i = 11; i < DEPTH - 5; i++) wr(DW'(100 + i));
    settle();
    chk("R7 loaded threshold DEPTH-5", afull_n, 1);
    wr(DW'(200));
    settle();
    chk("R7 loaded threshold DEPTH-4", afull_n, 0);
    drain_check("R3 data in programming mode");
  endtask

  task automatic t_concurrent();
    bit wdone = 0;
    do_reset(1);
    fork
      begin
        for (int k = 0; k < 400; k++) begin
          @(negedge wclk);
          din = DW'(k * 7 + 3);
          wen1_n = ($urandom % 4) == 0;
          if (!wen1_n && full_n) q.push_back(din);
        end
        @(negedge wclk); wen1_n = 1;
        wdone = 1;
      end
      begin
        bit pend = 0;
        logic [DW-1:0] e;
        while (!wdone || q.size() != 0 || pend) begin
          @(negedge rclk);
          if (pend) begin
            e = (q.size() > 0) ? q.pop_front() : 'x;
            chk("R4 concurrent stream", dout, e);
            pend = 0;
          end
          ren1_n = ($urandom % 2) == 0;
          ren2_n = ren1_n;
          if (!ren1_n && empty_n) pend = 1;
        end
        ren1_n = 1; ren2_n = 1;
      end
    join
  endtask

  initial begin
    #700000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_two_enable();
    t_default_thresholds();
    t_load();
    t_concurrent();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule